// File: doc/BRIEF.md
# I/O Page Bus Decoder

This block sits on the memory side of a CPU bus with a 16-bit byte address. Every cycle the CPU may present a command. The select strobe qualifies the command. A direction line chooses between reading and writing. The block sends each command either to a byte-wide RAM or to a small file of device registers. These registers sit in the top 4 KB of the address space, which is reserved for peripherals. Read results come back one clock later on a registered byte bus, together with a valid strobe and an error strobe.

The device file holds three 16-bit registers: a control/status word at octal 177160, a first data word at octal 177162 and a second data word at octal 177164. Each word is reached byte by byte. The even address selects the low byte and the odd address selects the high byte. The RAM model has a parameterized depth that is smaller than the full memory region. The rest of the memory region exists as address space only. It reads as zero and drops writes.

Top module: `iopage_bus_decoder`

## Requirements
- R1: While reset is held, and in the first cycle after it, `rd_valid`, `rd_err` and `rd_data` are 0, and all three device registers read back as zero.
- R2: With `sel` low, no storage changes and `rd_valid` stays low, whatever `rd_not_wr`, `addr` and `wdata` carry.
- R3: A command with `sel`=1 and `rd_not_wr`=0 at an address below `RAM_BYTES` stores `wdata` in that RAM byte. A write never raises `rd_valid`.
- R4: A command with `sel`=1 and `rd_not_wr`=1 raises `rd_valid` in the next cycle and puts the addressed byte on `rd_data`. Back-to-back reads return one result per cycle, in order.
- R5: Addresses 0x0000 to 0xEFFF (octal 0 to 167777) form the memory region. Addresses from 0xF000 (octal 170000) upward form the I/O page. Memory-region addresses at or above `RAM_BYTES` read as zero with no error, and writes to them are dropped.
- R6: The device registers sit at 0xFE70, 0xFE72 and 0xFE74 (octal 177160, 177162, 177164). Each is 16 bits. Address bit 0 = 0 selects bits 7:0 and bit 0 = 1 selects bits 15:8. A byte write leaves the other byte of the word unchanged.
- R7: A read of an I/O-page address with no register returns 0 with `rd_err` high in the same cycle as `rd_valid`. A write there is dropped and raises no error.
- R8: Writes to device registers never modify RAM, including the RAM byte whose index equals the low address bits of the register.
- R9: RAM bytes keep their contents across idle cycles and across writes to other addresses, until they are rewritten.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sel | input | 1 | Command strobe; 0 means no operation |
| rd_not_wr | input | 1 | 1 = read, 0 = write (when `sel` is 1) |
| addr | input | 16 | Byte address |
| wdata | input | 8 | Write byte |
| rd_data | output | 8 | Registered read byte |
| rd_valid | output | 1 | High one cycle after an accepted read |
| rd_err | output | 1 | High with `rd_valid` when the read hit an empty I/O-page slot |

## Verification
The hardest case to reach from the ports is aliasing. A device-register write could silently corrupt the RAM byte whose index equals the register address truncated to the RAM depth. An out-of-depth memory write could do the same to a low RAM byte. Nothing at the ports shows such damage until that RAM byte is read again. The stimulus therefore first plants known bytes at the alias indices (0x270, 0x000). It then performs the register writes and the out-of-depth writes, and reads the planted bytes back. A write to an empty I/O slot is likewise followed by reads of the slot and of its neighbouring register, to show that nothing was stored.

// File: rtl/iopage_pkg.sv
package iopage_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int WORD_W = 2 * DATA_W;

    // Start of the peripheral page; everything below is memory region
    localparam logic [ADDR_W-1:0] IO_PAGE_BASE = 16'o170000;
    // First device register; the others follow at word steps
    localparam logic [ADDR_W-1:0] DEV_BASE_DEFAULT = 16'o177160;

    typedef enum logic [1:0] {
        TGT_RAM  = 2'd0,   // backed RAM byte
        TGT_VOID = 2'd1,   // memory region beyond modelled depth
        TGT_DEV  = 2'd2,   // device register byte
        TGT_HOLE = 2'd3    // I/O page slot with no register
    } target_e;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_WRITE = 2'd1,
        CMD_READ  = 2'd2
    } cmd_e;

    typedef struct packed {
        target_e tgt;
        logic    hi_byte;
    } decode_t;

    function automatic cmd_e to_cmd(input logic sel, input logic rd_not_wr);
        if (!sel)
            return CMD_IDLE;
        return rd_not_wr ? CMD_READ : CMD_WRITE;
    endfunction

endpackage

// File: rtl/iopage_addr_decode.sv
module iopage_addr_decode
    import iopage_pkg::*;
#(
    parameter int                RAM_BYTES = 1024,
    parameter int                NUM_REGS  = 3,
    parameter logic [ADDR_W-1:0] DEV_BASE  = DEV_BASE_DEFAULT,
    localparam int RAM_IDX_W = (RAM_BYTES > 1) ? $clog2(RAM_BYTES) : 1,
    localparam int REG_IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic [ADDR_W-1:0]    addr,
    output decode_t              dec,
    output logic [RAM_IDX_W-1:0] ram_idx,
    output logic [REG_IDX_W-1:0] reg_idx
);

    localparam logic [ADDR_W:0] RAM_LIMIT = (ADDR_W + 1)'(RAM_BYTES);
    localparam logic [ADDR_W:0] DEV_SPAN  = (ADDR_W + 1)'(2 * NUM_REGS);

    logic [ADDR_W-1:0] dev_off;
    logic [ADDR_W-1:0] dev_word;

    assign dev_off  = addr - DEV_BASE;
    assign dev_word = dev_off >> 1;

    always_comb begin
        if (addr >= IO_PAGE_BASE) begin
            if (addr >= DEV_BASE && {1'b0, dev_off} < DEV_SPAN)
                dec.tgt = TGT_DEV;
            else
                dec.tgt = TGT_HOLE;
        end else if ({1'b0, addr} < RAM_LIMIT) begin
            dec.tgt = TGT_RAM;
        end else begin
            dec.tgt = TGT_VOID;
        end
        dec.hi_byte = addr[0];
    end

    assign ram_idx = addr[RAM_IDX_W-1:0];
    assign reg_idx = dev_word[REG_IDX_W-1:0];

endmodule

// File: rtl/iopage_ram.sv
module iopage_ram #(
    parameter int DEPTH  = 1024,
    parameter int DATA_W = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[idx] <= wdata;
    end

    assign rdata = mem[idx];

endmodule

// File: rtl/iopage_dev_regs.sv
module iopage_dev_regs #(
    parameter int NUM_REGS = 3,
    parameter int DATA_W   = 8,
    localparam int REG_IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int WORD_W    = 2 * DATA_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [REG_IDX_W-1:0] idx,
    input  logic                 hi_byte,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata
);

    localparam logic [REG_IDX_W:0] REG_COUNT = (REG_IDX_W + 1)'(NUM_REGS);

    logic [WORD_W-1:0]          regs [NUM_REGS];
    logic [NUM_REGS*WORD_W-1:0] regs_flat;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= '0;
            end else if (we && idx == REG_IDX_W'(g)) begin
                if (hi_byte)
                    regs[g][WORD_W-1:DATA_W] <= wdata;
                else
                    regs[g][DATA_W-1:0] <= wdata;
            end
        end
        assign regs_flat[g*WORD_W +: WORD_W] = regs[g];
    end

    always_comb begin
        rdata = '0;
        if ({1'b0, idx} < REG_COUNT)
            rdata = hi_byte ? regs[idx][WORD_W-1:DATA_W] : regs[idx][DATA_W-1:0];
    end

    // R2: the register file is left alone when no write is steered here
    p_regs_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(regs_flat));

    // R6: a byte write keeps the other byte of the addressed word
    p_other_byte_kept_r6: assert property (@(posedge clk) disable iff (rst)
        (we && hi_byte && {1'b0, idx} < REG_COUNT) |=>
            regs[$past(idx)][DATA_W-1:0] == $past(regs[idx][DATA_W-1:0]));

endmodule

// File: rtl/iopage_bus_decoder.sv
module iopage_bus_decoder
    import iopage_pkg::*;
#(
    parameter int                RAM_BYTES = 1024,
    parameter int                NUM_REGS  = 3,
    parameter logic [ADDR_W-1:0] DEV_BASE  = DEV_BASE_DEFAULT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              rd_not_wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              rd_err
);

    localparam int RAM_IDX_W = (RAM_BYTES > 1) ? $clog2(RAM_BYTES) : 1;
    localparam int REG_IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    cmd_e                 cmd;
    decode_t              dec;
    logic [RAM_IDX_W-1:0] ram_idx;
    logic [REG_IDX_W-1:0] reg_idx;
    logic                 ram_we;
    logic                 dev_we;
    logic [DATA_W-1:0]    ram_rd;
    logic [DATA_W-1:0]    dev_rd;
    logic [DATA_W-1:0]    rd_mux;

    assign cmd = to_cmd(sel, rd_not_wr);

    iopage_addr_decode #(
        .RAM_BYTES (RAM_BYTES),
        .NUM_REGS  (NUM_REGS),
        .DEV_BASE  (DEV_BASE)
    ) u_decode (
        .addr    (addr),
        .dec     (dec),
        .ram_idx (ram_idx),
        .reg_idx (reg_idx)
    );

    assign ram_we = (cmd == CMD_WRITE) && (dec.tgt == TGT_RAM);
    assign dev_we = (cmd == CMD_WRITE) && (dec.tgt == TGT_DEV);

    iopage_ram #(
        .DEPTH  (RAM_BYTES),
        .DATA_W (DATA_W)
    ) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .idx   (ram_idx),
        .wdata (wdata),
        .rdata (ram_rd)
    );

    iopage_dev_regs #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (dev_we),
        .idx     (reg_idx),
        .hi_byte (dec.hi_byte),
        .wdata   (wdata),
        .rdata   (dev_rd)
    );

    always_comb begin
        unique case (dec.tgt)
            TGT_RAM: rd_mux = ram_rd;
            TGT_DEV: rd_mux = dev_rd;
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
            rd_err   <= 1'b0;
        end else begin
            rd_valid <= (cmd == CMD_READ);
            rd_err   <= (cmd == CMD_READ) && (dec.tgt == TGT_HOLE);
            if (cmd == CMD_READ)
                rd_data <= rd_mux;
        end
    end

    // R4: every accepted read yields a result on the next cycle
    p_read_valid_next_r4: assert property (@(posedge clk) disable iff (rst)
        (sel && rd_not_wr) |=> rd_valid);

    // R2: an idle bus produces no response
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !sel |=> (!rd_valid && !rd_err));

    // R3: writes produce no response
    p_write_silent_r3: assert property (@(posedge clk) disable iff (rst)
        (sel && !rd_not_wr) |=> !rd_valid);

    // R7: an error always comes with valid and zero data
    p_err_zero_data_r7: assert property (@(posedge clk) disable iff (rst)
        rd_err |-> (rd_valid && rd_data == '0));

    // R5: the peripheral page never reaches the RAM path
    p_io_page_not_ram_r5: assert property (@(posedge clk) disable iff (rst)
        (addr >= IO_PAGE_BASE) |-> (dec.tgt == TGT_DEV || dec.tgt == TGT_HOLE));

    // R8: a register write and a RAM write never coincide
    p_single_target_r8: assert property (@(posedge clk) disable iff (rst)
        !(ram_we && dev_we));

endmodule

// File: tb/iopage_bus_decoder_test.sv
module iopage_bus_decoder_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel = 1'b0;
    logic        rd_not_wr = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic        rd_err;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [7:0] data;
        logic       err;
        string      tag;
    } exp_t;

    exp_t  sb[$];
    string last_tag = "R1";

    always #10 clk = ~clk;   // 50 MHz

    iopage_bus_decoder uut (
        .clk       (clk),
        .rst       (rst),
        .sel       (sel),
        .rd_not_wr (rd_not_wr),
        .addr      (addr),
        .wdata     (wdata),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .rd_err    (rd_err)
    );

    // Driver: one bus command per cycle; reads push the expected result
    task automatic cmd(input logic s, input logic r, input logic [15:0] a,
                       input logic [7:0] d, input logic [7:0] exp_d,
                       input logic exp_e, input string tag);
        exp_t item;
        @(negedge clk);
        sel = s; rd_not_wr = r; addr = a; wdata = d;
        @(posedge clk);
        #1;
        last_tag = tag;
        if (s && r) begin
            item.data = exp_d;
            item.err  = exp_e;
            item.tag  = tag;
            sb.push_back(item);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d, input string tag);
        cmd(1'b1, 1'b0, a, d, 8'h00, 1'b0, tag);
    endtask

    task automatic rd(input logic [15:0] a, input logic [7:0] exp_d,
                      input logic exp_e, input string tag);
        cmd(1'b1, 1'b1, a, 8'h00, exp_d, exp_e, tag);
    endtask

    task automatic idle(input int n, input logic r, input string tag);
        for (int i = 0; i < n; i++)
            cmd(1'b0, r, 16'o177160, 8'hEE, 8'h00, 1'b0, tag);
    endtask

    // Monitor: compares each response against the scoreboard head
    always @(negedge clk) begin
        if (!rst) begin
            checks++;
            if (rd_valid) begin
                if (sb.size() == 0) begin
                    fails++;
                    $display("FAIL %s: unexpected rd_valid, actual data=%02h err=%0b expected no response",
                             last_tag, rd_data, rd_err);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    if (rd_data !== e.data || rd_err !== e.err) begin
                        fails++;
                        $display("FAIL %s: actual data=%02h err=%0b expected data=%02h err=%0b",
                                 e.tag, rd_data, rd_err, e.data, e.err);
                    end
                end
            end else begin
                if (sb.size() != 0) begin
                    exp_t e;
                    e = sb.pop_front();
                    fails++;
                    $display("FAIL %s: actual rd_valid=0 expected rd_valid=1 data=%02h",
                             e.tag, e.data);
                end
                if (rd_err !== 1'b0) begin
                    fails++;
                    $display("FAIL R7: actual rd_err=%0b without rd_valid expected 0", rd_err);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog (R4): actual run still busy expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs cleared under reset
        checks++;
        if (rd_valid !== 1'b0 || rd_err !== 1'b0 || rd_data !== 8'h00) begin
            fails++;
            $display("FAIL R1: actual valid=%0b err=%0b data=%02h expected 0 0 00",
                     rd_valid, rd_err, rd_data);
        end
        rst = 1'b0;

        // R1: device registers are zero after reset
        rd(16'o177160, 8'h00, 1'b0, "R1");
        rd(16'o177161, 8'h00, 1'b0, "R1");
        rd(16'o177162, 8'h00, 1'b0, "R1");
        rd(16'o177165, 8'h00, 1'b0, "R1");

        // R3: RAM writes, including the last backed byte
        wr(16'h0000, 8'h11, "R3");
        wr(16'h0001, 8'h22, "R3");
        wr(16'h03FF, 8'h5A, "R3");
        wr(16'h0270, 8'h3C, "R3");
        // R4: back-to-back reads return in order
        rd(16'h0001, 8'h22, 1'b0, "R4");
        rd(16'h0000, 8'h11, 1'b0, "R4");
        rd(16'h03FF, 8'h5A, 1'b0, "R4");

        // R2: idle with the direction line in both states
        idle(3, 1'b0, "R2");
        idle(3, 1'b1, "R2");
        rd(16'o177160, 8'h00, 1'b0, "R2");
        rd(16'h0000, 8'h11, 1'b0, "R9");

        // R6: byte lanes of the device registers
        wr(16'o177160, 8'hA1, "R6");
        wr(16'o177161, 8'hB2, "R6");
        wr(16'o177162, 8'hC3, "R6");
        wr(16'o177165, 8'hD4, "R6");
        rd(16'o177160, 8'hA1, 1'b0, "R6");
        rd(16'o177161, 8'hB2, 1'b0, "R6");
        rd(16'o177162, 8'hC3, 1'b0, "R6");
        rd(16'o177163, 8'h00, 1'b0, "R6");
        rd(16'o177164, 8'h00, 1'b0, "R6");
        rd(16'o177165, 8'hD4, 1'b0, "R6");
        wr(16'o177160, 8'h5E, "R6");
        rd(16'o177161, 8'hB2, 1'b0, "R6");
        rd(16'o177160, 8'h5E, 1'b0, "R6");

        // R8: RAM byte sharing the register's low address bits is untouched
        rd(16'h0270, 8'h3C, 1'b0, "R8");

        // R7: empty I/O slots
        rd(16'hF000, 8'h00, 1'b1, "R7");
        rd(16'hFFFF, 8'h00, 1'b1, "R7");
        rd(16'o177166, 8'h00, 1'b1, "R7");
        rd(16'o177157, 8'h00, 1'b1, "R7");
        wr(16'o177166, 8'h77, "R7");
        rd(16'o177166, 8'h00, 1'b1, "R7");
        rd(16'o177164, 8'h00, 1'b0, "R7");

        // R5: region boundary and out-of-depth memory
        rd(16'hEFFF, 8'h00, 1'b0, "R5");
        wr(16'h0400, 8'h99, "R5");
        wr(16'hEC00, 8'h98, "R5");
        rd(16'h0400, 8'h00, 1'b0, "R5");
        rd(16'h0000, 8'h11, 1'b0, "R5");
        rd(16'h03FF, 8'h5A, 1'b0, "R9");
        rd(16'h0001, 8'h22, 1'b0, "R9");

        idle(3, 1'b0, "R2");
        checks++;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R4: actual %0d responses missing expected 0", sb.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule